// File: doc/BRIEF.md
# Warp Engine Command Token Decoder

This block sits in front of a geometric warp engine and turns a stream of 32-bit command tokens into the engine's configuration state. Each token arrives with a valid strobe; the block accepts one token per cycle and never stalls. A token with its top bit set is a configure token that writes one register directly. A token with its top bit clear is a data token, and data tokens are consumed as a fixed-length parameter sequence whose length and register targets depend on the programmed processing mode.

In scaling mode a sequence has three tokens: a packed ratio word, then a source address, then a destination address. In tetragon mode a sequence has ten tokens: eight corner coordinates, then the source and destination addresses. When the last token of a sequence is stored, the block raises a one-cycle job-start pulse, and the captured parameters can be read through a combinational read port and through decoded field outputs.

The sequencer has three named states. `SEQ_IDLE` waits for the first data token; on it the block moves to `SEQ_SCALE` (scaling mode) or `SEQ_TETRA` (tetragon mode). `SEQ_SCALE` and `SEQ_TETRA` count the tokens of their sequence and return to `SEQ_IDLE` on the final token (completion, pulse emitted). Any configure token, in any state, moves the machine to `SEQ_IDLE` (abort, no pulse).

Top module: `warp_token_decoder`

## Requirements
- R1: A token with bit 31 = 1 writes its bits 24:0 (zero-extended to 26 bits) into the register selected by bits 29:25; the value reads back on `rd_data` from the cycle after acceptance. `tok_ready` is always 1.
- R2: Register index 0 always reads 0; writes to index 0 and to indices 27 to 31 change no register, and `rd_idx` values 0 and 27 to 31 read 0.
- R3: After reset every register reads 0 (so scaling mode is selected), `job_start` is 0 and `dim_err` is 0.
- R4: In scaling mode (index 26 bit 0 = 0) three data tokens (bit 31 = 0) store their bits 25:0 into indices 4, 7 and 11 in that order; `job_start` is 1 for exactly the one cycle after the third token is accepted and 0 after the first two.
- R5: `ratio_frx`, `ratio_ipx` and `ratio_fry` show bits 9:0, 15:10 and 25:16 of register 4.
- R6: In tetragon mode (index 26 bit 0 = 1) ten data tokens store into indices 15, 16, 17, 18, 19, 20, 21, 22, 7, 11 in that order; `job_start` pulses for one cycle after the tenth and at no earlier point of the sequence.
- R7: A configure token accepted in the middle of a sequence still performs its write, ends the sequence without a `job_start` pulse, and the next data token is stored as the first of a new sequence.
- R8: A write to index 5 above `OX_LIMIT` (8128) or to index 6 above `OY_LIMIT` (4095) stores the limit instead and sets `dim_err`; a value equal to the limit is stored as is without setting it; `dim_err` stays set until reset.
- R9: `proc_mode` is bit 0 of index 26, `interp_type` bits 1:0 of index 24 (0 nearest, 1 bilinear, 2 bicubic, 3 table), `perf_point` bits 1:0 of index 23 (0 = 1x1, 1 = 2x1, 2 = 1x2, 3 = 2x2), `scan_order` bit 0 of index 25 (0 slide-to-bottom, 1 slide-to-right).
- R10: Token bit 30 (run-type flag) never changes decoding; `job_crun` shows bit 30 of the final token of a sequence during the `job_start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_ready | output | 1 | Token accepted (always 1) |
| tok_data | input | 32 | Command token |
| rd_idx | input | 5 | Read port register index |
| rd_data | output | 26 | Read port register value |
| proc_mode | output | 1 | 0 scaling, 1 tetragon |
| interp_type | output | 2 | Interpolation kind |
| perf_point | output | 2 | Pixels per cycle selection |
| scan_order | output | 1 | Scan direction |
| ratio_frx | output | 10 | X fraction field of the ratio word |
| ratio_ipx | output | 6 | X integer step field of the ratio word |
| ratio_fry | output | 10 | Y fraction field of the ratio word |
| job_start | output | 1 | One-cycle pulse on sequence completion |
| job_crun | output | 1 | Run-type flag of the completing token |
| dim_err | output | 1 | Sticky output-dimension clamp flag |

## Verification
The bench builds the block with its default limits, 8128 for the X dimension and 4095 for the Y dimension, so the clamp can be probed exactly at the limit, one step above it and far above it. With these values the stored result of each write is known without scaling the stimulus, which makes the boundary between an accepted and a clamped dimension directly observable on the read port and on the sticky flag.

// File: rtl/warp_tok_pkg.sv
package warp_tok_pkg;
    localparam int TOK_W   = 32;
    localparam int IDX_W   = 5;
    localparam int VAL_W   = 25;
    localparam int PAY_W   = 26;
    localparam int NREG    = 27;
    localparam int CMD_BIT = 31;
    localparam int RUN_BIT = 30;
    localparam int CNT_W   = 4;

    localparam int IX_RATIO  = 4;
    localparam int IX_OXDIM  = 5;
    localparam int IX_OYDIM  = 6;
    localparam int IX_SRC    = 7;
    localparam int IX_DST    = 11;
    localparam int IX_P0X    = 15;
    localparam int IX_PERF   = 23;
    localparam int IX_INTERP = 24;
    localparam int IX_SCAN   = 25;
    localparam int IX_MODE   = 26;

    localparam int N_CORNER  = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SCALE = 2'd1,
        SEQ_TETRA = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             is_cfg;
        logic             crun;
        logic [IDX_W-1:0] idx;
        logic [PAY_W-1:0] payload;
    } tok_fields_t;
endpackage

// File: rtl/warp_tok_parse.sv
module warp_tok_parse
    import warp_tok_pkg::*;
(
    input  logic [TOK_W-1:0] tok_data,
    output tok_fields_t      fields
);
    always_comb begin
        fields.is_cfg = tok_data[CMD_BIT];
        fields.crun   = tok_data[RUN_BIT];
        fields.idx    = tok_data[VAL_W +: IDX_W];
        if (tok_data[CMD_BIT])
            fields.payload = PAY_W'(tok_data[VAL_W-1:0]);
        else
            fields.payload = tok_data[PAY_W-1:0];
    end
endmodule

// File: rtl/warp_seq_fsm.sv
module warp_seq_fsm
    import warp_tok_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             is_cfg,
    input  logic             crun,
    input  logic             mode_tetra,
    output logic [IDX_W-1:0] data_idx,
    output logic             job_start,
    output logic             job_crun
);
    seq_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            cnt       <= '0;
            job_start <= 1'b0;
            job_crun  <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            job_start <= done;
            job_crun  <= done & crun;
        end
    end

    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        data_idx = '0;
        done     = 1'b0;
        if (accept) begin
            if (is_cfg) begin
                state_n = SEQ_IDLE;
                cnt_n   = '0;
            end else begin
                unique case (state)
                    SEQ_IDLE: begin
                        cnt_n = CNT_W'(1);
                        if (mode_tetra) begin
                            data_idx = IDX_W'(IX_P0X);
                            state_n  = SEQ_TETRA;
                        end else begin
                            data_idx = IDX_W'(IX_RATIO);
                            state_n  = SEQ_SCALE;
                        end
                    end
                    SEQ_SCALE: begin
                        if (cnt == CNT_W'(1)) begin
                            data_idx = IDX_W'(IX_SRC);
                            cnt_n    = CNT_W'(2);
                        end else begin
                            data_idx = IDX_W'(IX_DST);
                            done     = 1'b1;
                            state_n  = SEQ_IDLE;
                            cnt_n    = '0;
                        end
                    end
                    SEQ_TETRA: begin
                        if (cnt < CNT_W'(N_CORNER)) begin
                            data_idx = IDX_W'(IX_P0X) + IDX_W'(cnt);
                            cnt_n    = cnt + CNT_W'(1);
                        end else if (cnt == CNT_W'(N_CORNER)) begin
                            data_idx = IDX_W'(IX_SRC);
                            cnt_n    = cnt + CNT_W'(1);
                        end else begin
                            data_idx = IDX_W'(IX_DST);
                            done     = 1'b1;
                            state_n  = SEQ_IDLE;
                            cnt_n    = '0;
                        end
                    end
                    default: begin
                        state_n = SEQ_IDLE;
                        cnt_n   = '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/warp_reg_bank.sv
module warp_reg_bank
    import warp_tok_pkg::*;
#(
    parameter int OX_LIMIT = 8128,
    parameter int OY_LIMIT = 4095
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [PAY_W-1:0] wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PAY_W-1:0] rd_data,
    output logic [PAY_W-1:0] mode_word,
    output logic [PAY_W-1:0] interp_word,
    output logic [PAY_W-1:0] perf_word,
    output logic [PAY_W-1:0] scan_word,
    output logic [PAY_W-1:0] ratio_word,
    output logic             dim_err
);
    localparam logic [PAY_W-1:0] OX_MAX = PAY_W'(OX_LIMIT);
    localparam logic [PAY_W-1:0] OY_MAX = PAY_W'(OY_LIMIT);

    logic [PAY_W-1:0] regs [1:NREG-1];
    logic             over_x, over_y;

    assign over_x = we && (widx == IDX_W'(IX_OXDIM)) && (wdata > OX_MAX);
    assign over_y = we && (widx == IDX_W'(IX_OYDIM)) && (wdata > OY_MAX);

    for (genvar i = 1; i < NREG; i++) begin : g_slot
        logic [PAY_W-1:0] next_val;
        if (i == IX_OXDIM) begin : g_clx
            assign next_val = (wdata > OX_MAX) ? OX_MAX : wdata;
        end else if (i == IX_OYDIM) begin : g_cly
            assign next_val = (wdata > OY_MAX) ? OY_MAX : wdata;
        end else begin : g_plain
            assign next_val = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && widx == IDX_W'(i))
                regs[i] <= next_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dim_err <= 1'b0;
        else if (over_x || over_y)
            dim_err <= 1'b1;
    end

    always_comb begin
        if (rd_idx == '0 || rd_idx >= IDX_W'(NREG))
            rd_data = '0;
        else
            rd_data = regs[rd_idx];
    end

    assign mode_word   = regs[IX_MODE];
    assign interp_word = regs[IX_INTERP];
    assign perf_word   = regs[IX_PERF];
    assign scan_word   = regs[IX_SCAN];
    assign ratio_word  = regs[IX_RATIO];
endmodule

// File: rtl/warp_token_decoder.sv
module warp_token_decoder
    import warp_tok_pkg::*;
#(
    parameter int OX_LIMIT = 8128,
    parameter int OY_LIMIT = 4095
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tok_valid,
    output logic        tok_ready,
    input  logic [31:0] tok_data,
    input  logic [4:0]  rd_idx,
    output logic [25:0] rd_data,
    output logic        proc_mode,
    output logic [1:0]  interp_type,
    output logic [1:0]  perf_point,
    output logic        scan_order,
    output logic [9:0]  ratio_frx,
    output logic [5:0]  ratio_ipx,
    output logic [9:0]  ratio_fry,
    output logic        job_start,
    output logic        job_crun,
    output logic        dim_err
);
    tok_fields_t      f;
    logic [IDX_W-1:0] data_idx, widx;
    logic [PAY_W-1:0] mode_w, interp_w, perf_w, scan_w, ratio_w;
    logic             accept;

    assign tok_ready = 1'b1;
    assign accept    = tok_valid & tok_ready;

    warp_tok_parse u_parse (
        .tok_data (tok_data),
        .fields   (f)
    );

    warp_seq_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .is_cfg     (f.is_cfg),
        .crun       (f.crun),
        .mode_tetra (proc_mode),
        .data_idx   (data_idx),
        .job_start  (job_start),
        .job_crun   (job_crun)
    );

    assign widx = f.is_cfg ? f.idx : data_idx;

    warp_reg_bank #(
        .OX_LIMIT (OX_LIMIT),
        .OY_LIMIT (OY_LIMIT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (accept),
        .widx        (widx),
        .wdata       (f.payload),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .mode_word   (mode_w),
        .interp_word (interp_w),
        .perf_word   (perf_w),
        .scan_word   (scan_w),
        .ratio_word  (ratio_w),
        .dim_err     (dim_err)
    );

    assign proc_mode   = mode_w[0];
    assign interp_type = interp_w[1:0];
    assign perf_point  = perf_w[1:0];
    assign scan_order  = scan_w[0];
    assign ratio_frx   = ratio_w[9:0];
    assign ratio_ipx   = ratio_w[15:10];
    assign ratio_fry   = ratio_w[25:16];
endmodule

// File: rtl/warp_tok_checker.sv
module warp_tok_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tok_valid,
    input logic [31:0] tok_data,
    input logic [4:0]  rd_idx,
    input logic [25:0] rd_data,
    input logic        proc_mode,
    input logic        job_start,
    input logic        dim_err
);
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start);

    assert_job_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> $past(tok_valid && !tok_data[31]));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dim_err |=> dim_err);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dim_err) |-> $past(tok_valid && tok_data[31] &&
                                 (tok_data[29:25] == 5'd5 || tok_data[29:25] == 5'd6)));

    assert_mode_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(proc_mode) |-> $past(tok_valid && tok_data[31] && tok_data[29:25] == 5'd26));

    assert_status_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 5'd0 || rd_idx > 5'd26) |-> rd_data == 26'd0);
endmodule

bind warp_token_decoder warp_tok_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_data  (tok_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .proc_mode (proc_mode),
    .job_start (job_start),
    .dim_err   (dim_err)
);

// File: tb/tb_warp_token_decoder.sv
module tb_warp_token_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic        tok_ready;
    logic [31:0] tok_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [25:0] rd_data;
    logic        proc_mode, scan_order, job_start, job_crun, dim_err;
    logic [1:0]  interp_type, perf_point;
    logic [9:0]  ratio_frx, ratio_fry;
    logic [5:0]  ratio_ipx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    warp_token_decoder dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_data(tok_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .proc_mode(proc_mode), .interp_type(interp_type), .perf_point(perf_point),
        .scan_order(scan_order), .ratio_frx(ratio_frx), .ratio_ipx(ratio_ipx),
        .ratio_fry(ratio_fry), .job_start(job_start), .job_crun(job_crun),
        .dim_err(dim_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // configure token: bit31=1, bit30 run flag, 29:25 index, 24:0 value
    function automatic logic [31:0] cfg_tok(input logic [4:0] idx, input logic [24:0] v,
                                            input logic crun);
        return {1'b1, crun, idx, v};
    endfunction

    // data token: bit31=0, bit30 run flag, 25:0 payload
    function automatic logic [31:0] dat_tok(input logic [25:0] v, input logic crun);
        return {1'b0, crun, 4'b0, v};
    endfunction

    // returns at the falling edge after the accepting rising edge
    task automatic send(input logic [31:0] t);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_data  = t;
        @(negedge clk);
        tok_valid = 1'b0;
        tok_data  = '0;
    endtask

    task automatic read_chk(input string tag, input logic [4:0] idx, input logic [25:0] exp);
        rd_idx = idx;
        #0.5;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic t_reset;
        chk("R3 job_start", 32'(job_start), 0);
        chk("R3 dim_err", 32'(dim_err), 0);
        chk("R3 proc_mode", 32'(proc_mode), 0);
        chk("R3 tok_ready", 32'(tok_ready), 1);
        read_chk("R3 reg26", 5'd26, 26'd0);
        read_chk("R3 reg4", 5'd4, 26'd0);
    endtask

    task automatic t_config;
        send(cfg_tok(5'd1, 25'h1ABCDEF, 1'b1));
        read_chk("R1 reg1", 5'd1, 26'h1ABCDEF);
        chk("R1 no job", 32'(job_start), 0);
        send(cfg_tok(5'd12, 25'h0000077, 1'b0));
        read_chk("R1 reg12", 5'd12, 26'h77);
    endtask

    task automatic t_ignored;
        send(cfg_tok(5'd0, 25'h123, 1'b0));
        read_chk("R2 reg0", 5'd0, 26'd0);
        send(cfg_tok(5'd27, 25'h456, 1'b0));
        read_chk("R2 reg27", 5'd27, 26'd0);
        send(cfg_tok(5'd31, 25'h1, 1'b0));
        read_chk("R2 reg31", 5'd31, 26'd0);
        read_chk("R2 reg26 untouched", 5'd26, 26'd0);
        read_chk("R2 reg1 untouched", 5'd1, 26'h1ABCDEF);
    endtask

    task automatic t_fields;
        send(cfg_tok(5'd24, 25'd2, 1'b0));
        send(cfg_tok(5'd23, 25'd3, 1'b0));
        send(cfg_tok(5'd25, 25'd1, 1'b0));
        chk("R9 interp", 32'(interp_type), 2);
        chk("R9 perf", 32'(perf_point), 3);
        chk("R9 scan", 32'(scan_order), 1);
        chk("R9 mode", 32'(proc_mode), 0);
    endtask

    task automatic t_scale;
        logic [25:0] ratio;
        ratio = {10'h155, 6'h2A, 10'h3C3};
        send(dat_tok(ratio, 1'b1));
        chk("R4 no job after 1", 32'(job_start), 0);
        send(dat_tok(26'h0100, 1'b0));
        chk("R4 no job after 2", 32'(job_start), 0);
        send(dat_tok(26'h0200, 1'b1));
        chk("R4 job after 3", 32'(job_start), 1);
        chk("R10 crun on job", 32'(job_crun), 1);
        @(negedge clk);
        chk("R4 single pulse", 32'(job_start), 0);
        read_chk("R4 ratio reg", 5'd4, ratio);
        read_chk("R4 src", 5'd7, 26'h0100);
        read_chk("R4 dst", 5'd11, 26'h0200);
        chk("R5 frx", 32'(ratio_frx), 32'h3C3);
        chk("R5 ipx", 32'(ratio_ipx), 32'h2A);
        chk("R5 fry", 32'(ratio_fry), 32'h155);
    endtask

    task automatic t_tetra;
        logic [4:0] order [10];
        order = '{5'd15, 5'd16, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd7, 5'd11};
        send(cfg_tok(5'd26, 25'd1, 1'b1));
        chk("R9 mode tetra", 32'(proc_mode), 1);
        for (int k = 0; k < 10; k++) begin
            send(dat_tok(26'h1000 + 26'(k), k[0]));
            if (k < 9) chk("R6 no early job", 32'(job_start), 0);
        end
        chk("R6 job after 10", 32'(job_start), 1);
        chk("R10 crun on job", 32'(job_crun), 1);
        for (int k = 0; k < 10; k++)
            read_chk("R6 target", order[k], 26'h1000 + 26'(k));
    endtask

    task automatic t_abort;
        for (int k = 0; k < 3; k++) send(dat_tok(26'h2000 + 26'(k), 1'b0));
        send(cfg_tok(5'd2, 25'h55, 1'b0));
        chk("R7 no job on abort", 32'(job_start), 0);
        read_chk("R7 cfg written", 5'd2, 26'h55);
        send(dat_tok(26'h3000, 1'b0));
        read_chk("R7 restart at first", 5'd15, 26'h3000);
        read_chk("R7 second slot kept", 5'd16, 26'h2001);
        for (int k = 1; k < 10; k++) begin
            send(dat_tok(26'h3000 + 26'(k), 1'b0));
            if (k < 9) chk("R7 no early job", 32'(job_start), 0);
        end
        chk("R7 job after full restart", 32'(job_start), 1);
        chk("R10 crun zero", 32'(job_crun), 0);
        read_chk("R7 dst", 5'd11, 26'h3009);
    endtask

    task automatic t_clamp;
        send(cfg_tok(5'd6, 25'd4095, 1'b0));
        read_chk("R8 oy at limit", 5'd6, 26'd4095);
        send(cfg_tok(5'd5, 25'd8128, 1'b0));
        read_chk("R8 ox at limit", 5'd5, 26'd8128);
        chk("R8 no err at limit", 32'(dim_err), 0);
        send(cfg_tok(5'd5, 25'd8129, 1'b0));
        read_chk("R8 ox clamped", 5'd5, 26'd8128);
        chk("R8 err set", 32'(dim_err), 1);
        send(cfg_tok(5'd6, 25'h1FFFFFF, 1'b0));
        read_chk("R8 oy clamped", 5'd6, 26'd4095);
        send(cfg_tok(5'd5, 25'd10, 1'b0));
        read_chk("R8 ox small", 5'd5, 26'd10);
        chk("R8 err sticky", 32'(dim_err), 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_ignored();
        t_fields();
        t_scale();
        t_tetra();
        t_abort();
        t_clamp();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule